// File: doc/BRIEF.md
# GPIO bank with interrupt sensing

This block controls one bank of sixteen general-purpose pins from a 32-bit register port. For each pin, software sets whether the pin drives or receives, which value it drives, whether the pad's input path is open, and whether the pin takes part in data accesses at all. The block drives the pad output value, the output enable and the input enable straight from these settings.

Each pad input passes through a two-flop synchronizer. The synchronized value feeds a per-pin detector that can sense a rising edge, a falling edge, either edge, a high level or a low level. Edge events stay latched until software writes a one to the pin's clear bit. Level conditions follow the pin directly. The raw status is ANDed with a per-pin enable to give the masked status, and any masked bit raises the single bank interrupt line.

Top module: `gpio_bank_irq`

## Requirements
- R1: Registers are word-aligned at these byte offsets: 0x00 pin data, 0x04 access mask, 0x08 direction, 0x0C sense select, 0x10 any-edge, 0x14 polarity, 0x18 interrupt enable, 0x1C raw status (read only), 0x20 masked status (read only), 0x24 clear (write only, reads 0), 0x28 input enable. Pin n is bit n of each register. Bits 31:16 read as 0 and writes to them are ignored. Other offsets read as 0.
- R2: pad_out[n] is the stored data bit of pin n, and pad_oe[n] is its direction bit (1 means output).
- R3: pad_ie mirrors the input-enable register. When an unmasked pin has input enable 1, reading data returns the pad value two clocks after it changes. When input enable is 0, the read returns the stored data bit.
- R4: A pin whose access-mask bit is 0 reads back 0 at offset 0x00, and a data write leaves its stored bit unchanged.
- R5: With sense 0, any-edge 0 and polarity 1, a rising edge on the synchronized input sets the pin's raw status bit. The bit stays set while the input returns low.
- R6: With sense 0, any-edge 0 and polarity 0, a falling edge sets the raw status bit and it stays set.
- R7: With sense 0 and any-edge 1, either transition sets the raw status bit, whatever the polarity.
- R8: With sense 1, the raw status bit equals 1 while the synchronized input equals the polarity bit (1 = active high, 0 = active low). It is not latched.
- R9: Writing 1 to a clear bit resets that pin's latched edge status, and writing 0 has no effect. In level mode a clear write leaves raw status following the input.
- R10: Masked status equals raw status AND interrupt enable, and irq is the OR of the masked status bits.
- R11: After reset every register reads 0, and pad_oe, pad_out, pad_ie and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| pad_in | input | 16 | Asynchronous pad input values |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| pad_ie | output | 16 | Pad input enables |
| irq | output | 1 | Bank interrupt, active high |

## Verification
The assertions assume that rst_n is already synchronized to clk and that each register access lasts exactly one strobe cycle. They also assume a pad input changes at most once every two clocks, so the synchronizer never merges two transitions. The stimulus drives pads and bus signals only on falling clock edges and holds each random pad pattern for several cycles. Before it samples status, it changes configuration only while the pads are quiet and clears any stale edge status.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int OFS_PIN    = 'h00;
  localparam int OFS_ACCMSK = 'h04;
  localparam int OFS_DRIVE  = 'h08;
  localparam int OFS_LEVEL  = 'h0C;
  localparam int OFS_ANYEDG = 'h10;
  localparam int OFS_POLAR  = 'h14;
  localparam int OFS_IRQEN  = 'h18;
  localparam int OFS_RAW    = 'h1C;
  localparam int OFS_MASKED = 'h20;
  localparam int OFS_CLEAR  = 'h24;
  localparam int OFS_INOPEN = 'h28;

  typedef enum logic [3:0] {
    SEL_PIN, SEL_ACCMSK, SEL_DRIVE, SEL_LEVEL, SEL_ANYEDG, SEL_POLAR,
    SEL_IRQEN, SEL_RAW, SEL_MASKED, SEL_CLEAR, SEL_INOPEN, SEL_NONE
  } gpio_sel_e;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_bank_sense.sv
module gpio_bank_sense #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] level_sel,
  input  logic [WIDTH-1:0] any_edge,
  input  logic [WIDTH-1:0] polarity,
  input  logic [WIDTH-1:0] clr_pulse,
  output logic [WIDTH-1:0] raw_stat
);

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic prev_q;
    logic hold_q;
    logic hold_d;
    logic rise;
    logic fall;
    logic hit;

    always_comb begin
      rise = pin_sync[p] & ~prev_q;
      fall = ~pin_sync[p] & prev_q;
      if (any_edge[p]) begin
        hit = rise | fall;
      end else if (polarity[p]) begin
        hit = rise;
      end else begin
        hit = fall;
      end

      hold_d = hold_q;
      if (level_sel[p]) begin
        hold_d = 1'b0;
      end else if (hit) begin
        hold_d = 1'b1;
      end else if (clr_pulse[p]) begin
        hold_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        prev_q <= pin_sync[p];
        hold_q <= hold_d;
      end
    end

    assign raw_stat[p] = level_sel[p] ? ~(pin_sync[p] ^ polarity[p]) : hold_q;

    // R5 R6 R7: a detected edge in edge mode is held in the next cycle
    assert_edge_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_sel[p] && hit) |=> hold_q)
      else $error("edge not latched on pin %0d", p);

    // R9: a clear with no competing edge drops the latch
    assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_sel[p] && !hit && clr_pulse[p]) |=> !hold_q)
      else $error("clear ignored on pin %0d", p);

    // R8: level mode keeps nothing latched
    assert_level_unlatched_R8: assert property (@(posedge clk) disable iff (!rst_n)
      level_sel[p] |=> !hold_q)
      else $error("latch set in level mode on pin %0d", p);
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [WIDTH-1:0]  pin_sync,
  input  logic [WIDTH-1:0]  raw_stat,
  output logic [WIDTH-1:0]  data_o,
  output logic [WIDTH-1:0]  drive_o,
  output logic [WIDTH-1:0]  level_o,
  output logic [WIDTH-1:0]  anyedge_o,
  output logic [WIDTH-1:0]  polar_o,
  output logic [WIDTH-1:0]  irqen_o,
  output logic [WIDTH-1:0]  inopen_o,
  output logic [WIDTH-1:0]  clr_pulse_o
);

  localparam int PAD_W = DATA_W - WIDTH;

  logic [WIDTH-1:0] data_q, data_d;
  logic [WIDTH-1:0] accmsk_q, accmsk_d;
  logic [WIDTH-1:0] drive_q, drive_d;
  logic [WIDTH-1:0] level_q, level_d;
  logic [WIDTH-1:0] anyedg_q, anyedg_d;
  logic [WIDTH-1:0] polar_q, polar_d;
  logic [WIDTH-1:0] irqen_q, irqen_d;
  logic [WIDTH-1:0] inopen_q, inopen_d;
  logic [WIDTH-1:0] wval;
  logic [WIDTH-1:0] rd_val;
  logic             wr_en;
  logic             rd_en;
  gpio_sel_e        sel;
  logic             unused_hi;

  assign wval      = bus_wdata[WIDTH-1:0];
  assign unused_hi = ^bus_wdata[DATA_W-1:WIDTH];
  assign wr_en     = bus_sel & bus_wr;
  assign rd_en     = bus_sel & ~bus_wr;

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_PIN):    sel = SEL_PIN;
      ADDR_W'(OFS_ACCMSK): sel = SEL_ACCMSK;
      ADDR_W'(OFS_DRIVE):  sel = SEL_DRIVE;
      ADDR_W'(OFS_LEVEL):  sel = SEL_LEVEL;
      ADDR_W'(OFS_ANYEDG): sel = SEL_ANYEDG;
      ADDR_W'(OFS_POLAR):  sel = SEL_POLAR;
      ADDR_W'(OFS_IRQEN):  sel = SEL_IRQEN;
      ADDR_W'(OFS_RAW):    sel = SEL_RAW;
      ADDR_W'(OFS_MASKED): sel = SEL_MASKED;
      ADDR_W'(OFS_CLEAR):  sel = SEL_CLEAR;
      ADDR_W'(OFS_INOPEN): sel = SEL_INOPEN;
      default:             sel = SEL_NONE;
    endcase
  end

  always_comb begin
    data_d   = data_q;
    accmsk_d = accmsk_q;
    drive_d  = drive_q;
    level_d  = level_q;
    anyedg_d = anyedg_q;
    polar_d  = polar_q;
    irqen_d  = irqen_q;
    inopen_d = inopen_q;
    clr_pulse_o = '0;
    if (wr_en) begin
      case (sel)
        SEL_PIN:    data_d   = (data_q & ~accmsk_q) | (wval & accmsk_q);
        SEL_ACCMSK: accmsk_d = wval;
        SEL_DRIVE:  drive_d  = wval;
        SEL_LEVEL:  level_d  = wval;
        SEL_ANYEDG: anyedg_d = wval;
        SEL_POLAR:  polar_d  = wval;
        SEL_IRQEN:  irqen_d  = wval;
        SEL_INOPEN: inopen_d = wval;
        SEL_CLEAR:  clr_pulse_o = wval;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      accmsk_q <= '0;
      drive_q  <= '0;
      level_q  <= '0;
      anyedg_q <= '0;
      polar_q  <= '0;
      irqen_q  <= '0;
      inopen_q <= '0;
    end else begin
      data_q   <= data_d;
      accmsk_q <= accmsk_d;
      drive_q  <= drive_d;
      level_q  <= level_d;
      anyedg_q <= anyedg_d;
      polar_q  <= polar_d;
      irqen_q  <= irqen_d;
      inopen_q <= inopen_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_PIN:    rd_val = accmsk_q & ((inopen_q & pin_sync) | (~inopen_q & data_q));
      SEL_ACCMSK: rd_val = accmsk_q;
      SEL_DRIVE:  rd_val = drive_q;
      SEL_LEVEL:  rd_val = level_q;
      SEL_ANYEDG: rd_val = anyedg_q;
      SEL_POLAR:  rd_val = polar_q;
      SEL_IRQEN:  rd_val = irqen_q;
      SEL_RAW:    rd_val = raw_stat;
      SEL_MASKED: rd_val = raw_stat & irqen_q;
      SEL_INOPEN: rd_val = inopen_q;
      default:    rd_val = '0;
    endcase
  end

  assign bus_rdata = rd_en ? {{PAD_W{1'b0}}, rd_val} : '0;

  assign data_o    = data_q;
  assign drive_o   = drive_q;
  assign level_o   = level_q;
  assign anyedge_o = anyedg_q;
  assign polar_o   = polar_q;
  assign irqen_o   = irqen_q;
  assign inopen_o  = inopen_q;

  // R4: a data write never alters pins whose access-mask bit was 0
  assert_masked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_PIN) |=> (((data_q ^ $past(data_q)) & ~$past(accmsk_q)) == '0))
    else $error("masked-off pin data changed");

  // R1: the clear register never reads back anything but zero
  assert_clear_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_CLEAR) |-> (bus_rdata == '0))
    else $error("clear register read nonzero");

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int NPINS  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_ie,
  output logic              irq
);

  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] raw_stat;
  logic [NPINS-1:0] level_sel;
  logic [NPINS-1:0] any_edge;
  logic [NPINS-1:0] polarity;
  logic [NPINS-1:0] irq_en;
  logic [NPINS-1:0] clr_pulse;

  gpio_bank_sync #(.WIDTH(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_bank_sense #(.WIDTH(NPINS)) u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_sync  (pin_sync),
    .level_sel (level_sel),
    .any_edge  (any_edge),
    .polarity  (polarity),
    .clr_pulse (clr_pulse),
    .raw_stat  (raw_stat)
  );

  gpio_bank_regs #(.WIDTH(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pin_sync    (pin_sync),
    .raw_stat    (raw_stat),
    .data_o      (pad_out),
    .drive_o     (pad_oe),
    .level_o     (level_sel),
    .anyedge_o   (any_edge),
    .polar_o     (polarity),
    .irqen_o     (irq_en),
    .inopen_o    (pad_ie),
    .clr_pulse_o (clr_pulse)
  );

  assign irq = |(raw_stat & irq_en);

  // R10: with every enable low the bank line stays quiet
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq)
    else $error("irq raised with all enables low");

  // R10: the line is never raised without some raw status behind it
  assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_stat != '0))
    else $error("irq without raw status");

endmodule

// File: tb/tb_gpio_bank_irq.sv
`timescale 1ns/1ps
module tb_gpio_bank_irq;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in;
  logic [15:0] pad_out;
  logic [15:0] pad_oe;
  logic [15:0] pad_ie;
  logic        irq;

  int tests;
  int fails;
  bit done;

  gpio_bank_irq dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_raw(input logic [15:0] a, input logic [15:0] b,
                                           input logic [15:0] lvl, input logic [15:0] both,
                                           input logic [15:0] pol);
    logic [15:0] rise, fall, edg;
    rise = b & ~a;
    fall = a & ~b;
    edg  = (both & (rise | fall)) | (~both & ((pol & rise) | (~pol & fall)));
    return (lvl & ~(b ^ pol)) | (~lvl & edg);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] a, b, lv, bo, po, en, ex;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R11: reset state
    for (int k = 0; k <= 'h28; k += 4) begin
      rd(8'(k), r);
      check($sformatf("R11 reset read %h", k), r, 32'h0);
    end
    check("R11 pad_oe", {16'h0, pad_oe}, 32'h0);
    check("R11 pad_out", {16'h0, pad_out}, 32'h0);
    check("R11 pad_ie", {16'h0, pad_ie}, 32'h0);
    check("R11 irq", {31'h0, irq}, 32'h0);

    // R1: upper bits, clear register, unmapped and read-only offsets
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, r); check("R1 upper bits dropped", r, 32'h0000_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, r); check("R1 clear reads zero", r, 32'h0);
    rd(8'h2C, r); check("R1 unmapped reads zero", r, 32'h0);
    wr(8'h1C, 32'h0000_FFFF);
    rd(8'h1C, r); check("R1 raw status not writable", r, 32'h0);

    // R2: pad drive follows direction and data
    wr(8'h08, 32'h0000_00F0);
    wr(8'h04, 32'h0000_FFFF);
    wr(8'h00, 32'h0000_1234);
    idle(1);
    check("R2 pad_oe", {16'h0, pad_oe}, 32'h0000_00F0);
    check("R2 pad_out", {16'h0, pad_out}, 32'h0000_1234);

    // R4: access mask blocks writes and reads
    wr(8'h04, 32'h0000_00FF);
    wr(8'h00, 32'h0000_FFFF);
    idle(1);
    check("R4 masked write", {16'h0, pad_out}, 32'h0000_12FF);
    rd(8'h00, r); check("R4 masked read", r, 32'h0000_00FF);

    // R3: input enable routes the synchronized pad onto data reads
    wr(8'h04, 32'h0000_FFFF);
    wr(8'h28, 32'h0000_FF00);
    pad_in = 16'hA5C3;
    idle(3);
    check("R3 pad_ie", {16'h0, pad_ie}, 32'h0000_FF00);
    rd(8'h00, r); check("R3 input read", r, 32'h0000_A5FF);
    wr(8'h28, 32'h0);
    pad_in = 16'h0;
    idle(4);

    // R5 R9: rising edge latched, clear 0 ignored, clear 1 resets
    wr(8'h0C, 32'h0); wr(8'h10, 32'h0); wr(8'h14, 32'h0000_0001);
    wr(8'h24, 32'h0000_FFFF);
    pad_in = 16'h0001; idle(4); pad_in = 16'h0; idle(4);
    rd(8'h1C, r); check("R5 rising latched", r, 32'h0000_0001);
    wr(8'h24, 32'h0000_FFFE);
    rd(8'h1C, r); check("R9 clear zero ignored", r, 32'h0000_0001);
    wr(8'h24, 32'h0000_0001);
    rd(8'h1C, r); check("R9 clear one resets", r, 32'h0);

    // R8 R9: level-high ignores clear
    wr(8'h0C, 32'h0000_0001);
    pad_in = 16'h0001; idle(4);
    wr(8'h24, 32'h0000_0001);
    rd(8'h1C, r); check("R9 level survives clear", r, 32'h0000_0001);
    pad_in = 16'h0; idle(4);
    rd(8'h1C, r); check("R8 level not latched", r, 32'h0);

    // Random mix over R5 R6 R7 R8 R10
    for (int it = 0; it < 40; it++) begin
      lv = 16'($urandom); bo = 16'($urandom); po = 16'($urandom); en = 16'($urandom);
      a = 16'($urandom); b = 16'($urandom);
      wr(8'h0C, {16'h0, lv}); wr(8'h10, {16'h0, bo});
      wr(8'h14, {16'h0, po}); wr(8'h18, {16'h0, en});
      pad_in = a; idle(5);
      wr(8'h24, 32'h0000_FFFF);
      idle(1);
      pad_in = b; idle(5);
      ex = exp_raw(a, b, lv, bo, po);
      rd(8'h1C, r); check($sformatf("R5 R6 R7 R8 raw it%0d", it), r, {16'h0, ex});
      rd(8'h20, r); check($sformatf("R10 masked it%0d", it), r, {16'h0, ex & en});
      check($sformatf("R10 irq it%0d", it), {31'h0, irq}, {31'h0, |(ex & en)});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule